// File: doc/BRIEF.md
# Descriptor Ring Fetch Manager

This block follows a ring of fixed-size command descriptors that software builds in host memory. It keeps a local descriptor FIFO filled by sending block read requests to a bus master. Software sets the ring base, the ring length, the descriptor geometry and the fetch block parameters through a small word-addressed register port. It then announces new work by writing a word count into the prepared-count register. The block tracks the ring read pointer and the number of prepared words not yet fetched. When the FIFO reports enough free room for a whole block, it issues one read request over a request/grant handshake. The request carries a byte address and a word length.

A downstream consumer pulses `desc_consumed` once per descriptor taken out of the FIFO. Each pulse raises the processed count by one descriptor stride. When the processed count goes above a programmed threshold, a sticky status flag drives `irq`. Software clears the flag by writing one to it.

The sequencer has three states:
- `ST_IDLE` waits for a fetch condition and latches the request.
- `ST_REQ` holds the request until it is granted.
- `ST_ADV` moves the pointer on and retires the fetched words.

The transitions are:
- launch: `ST_IDLE` to `ST_REQ`
- granted: `ST_REQ` to `ST_ADV`
- retire: `ST_ADV` to `ST_IDLE`
- abort: from any state to `ST_IDLE`, when the prepared count is reset

All counts, sizes and pointers are in 32-bit words. Register index map (`reg_addr`):

| Index | Register | Content |
|---|---|---|
| 0 | base low | bits 31:0 of the ring base byte address |
| 1 | base high | bits 63:32 of the ring base byte address |
| 2 | ring size | ring length in words |
| 3 | descriptor word | bits 15:0 size, bits 29:16 stride, bit 30 extra token flag |
| 4 | fetch configuration | bits 15:0 fetch size, bits 31:16 fetch threshold |
| 5 | prepared count | reads the pending words |
| 6 | processed count | processed words |
| 7 | status | bit 0 is the threshold flag |
| 8 | processed threshold | threshold for the processed count |

Top module: `drf_ring_fetch`

## Requirements
- R1: After reset `rd_req` and `irq` are 0, and the ring size, prepared count, processed count and status registers read 0.
- R2: The base low/high, ring size and fetch configuration registers read back the written value. The descriptor word reads back bits 15:0 (size), 29:16 (stride) and 30 (token flag).
- R3: While the fetch size field (configuration bits 15:0) is zero, no request is issued, even with pending words and an empty FIFO. Writing a non-zero fetch size lets the pending fetch start.
- R4: A request is launched only when FIFO_WORDS minus `fifo_level` is at least the fetch threshold (configuration bits 31:16).
- R5: `rd_len` is the smallest of the fetch size, the pending word count and the words left before the ring end. It is never zero.
- R6: `rd_addr` equals the 64-bit base plus four times the read pointer. After a grant the pointer advances by `rd_len` and wraps to 0 when it reaches the ring size.
- R7: Once raised, `rd_req` stays high with `rd_addr` and `rd_len` unchanged until `rd_gnt` is seen.
- R8: A write to the prepared count with bit 31 clear adds the low bits to the pending count. Each granted request subtracts its `rd_len`. Reading index 5 returns the pending count.
- R9: A write to the prepared count with bit 31 set clears the pending count and returns the read pointer to 0. Any request that is not yet granted is abandoned.
- R10: Each `desc_consumed` pulse adds the stride to the processed count. A write to index 6 with bit 31 clear subtracts the low bits. A write with bit 31 set clears the count.
- R11: `irq` (status bit 0) rises the cycle after the processed count exceeds the threshold. It stays set until a write of 1 to status bit 0 while the count no longer exceeds the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fifo_level | input | LVL_W | Descriptor FIFO fill level in words |
| desc_consumed | input | 1 | One descriptor left the FIFO |
| rd_req | output | 1 | Block read request |
| rd_gnt | input | 1 | Request accepted |
| rd_addr | output | 64 | Request byte address |
| rd_len | output | CNT_W | Request length in words |
| irq | output | 1 | Processed-threshold interrupt |

## Verification
Four properties are checked on every cycle:
- the request hold rule while waiting for a grant;
- that a launch only follows a cycle with a non-zero fetch size and enough free FIFO room;
- that the length stays within the fetch size and is never zero;
- that an advance which reaches the ring end leaves the pointer at 0.

The bench scenarios show the rest:
- the exact request lengths and byte addresses along a wrapping ring;
- the pending-count bookkeeping;
- the reset-code behaviour of both count registers;
- the set and write-one-to-clear sequence of the interrupt.

// File: rtl/drf_pkg.sv
package drf_pkg;
    localparam logic [3:0] A_BASE_LO = 4'd0;
    localparam logic [3:0] A_BASE_HI = 4'd1;
    localparam logic [3:0] A_RSIZE   = 4'd2;
    localparam logic [3:0] A_DESC    = 4'd3;
    localparam logic [3:0] A_CFG     = 4'd4;
    localparam logic [3:0] A_PREP    = 4'd5;
    localparam logic [3:0] A_PROC    = 4'd6;
    localparam logic [3:0] A_STAT    = 4'd7;
    localparam logic [3:0] A_PTHR    = 4'd8;

    localparam int RST_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ADV  = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/drf_regs.sv
module drf_regs
    import drf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [3:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             consumed,
    input  logic             sub_vld,
    input  logic [CNT_W-1:0] sub_len,
    input  logic             irq_flag,
    output logic [63:0]      base,
    output logic [CNT_W-1:0] ring_size,
    output logic [31:0]      cfg_word,
    output logic [CNT_W-1:0] pending,
    output logic [CNT_W-1:0] proc_cnt,
    output logic [CNT_W-1:0] proc_thr,
    output logic             clr_ptr,
    output logic             st_w1c
);
    logic [15:0]      dsize_q;
    logic [CNT_W-1:0] stride_q;
    logic             tok_q;
    logic [CNT_W-1:0] pend_add, pend_n;
    logic [CNT_W-1:0] proc_sub, proc_add, proc_n;
    logic             prep_wr, proc_wr, proc_clr;

    assign prep_wr  = wr && (addr == A_PREP);
    assign proc_wr  = wr && (addr == A_PROC);
    assign clr_ptr  = prep_wr && wdata[RST_BIT];
    assign proc_clr = proc_wr && wdata[RST_BIT];
    assign st_w1c   = wr && (addr == A_STAT) && wdata[0];

    always_comb begin
        pend_add = (prep_wr && !wdata[RST_BIT]) ? wdata[CNT_W-1:0] : '0;
        if (clr_ptr)
            pend_n = '0;
        else
            pend_n = pending + pend_add - (sub_vld ? sub_len : '0);
        proc_sub = (proc_wr && !wdata[RST_BIT]) ? wdata[CNT_W-1:0] : '0;
        proc_add = consumed ? stride_q : '0;
        if (proc_clr)
            proc_n = '0;
        else
            proc_n = proc_cnt + proc_add - proc_sub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            ring_size <= '0;
            cfg_word  <= '0;
            dsize_q   <= '0;
            stride_q  <= '0;
            tok_q     <= 1'b0;
            proc_thr  <= '0;
            pending   <= '0;
            proc_cnt  <= '0;
        end else begin
            pending  <= pend_n;
            proc_cnt <= proc_n;
            if (wr) begin
                unique case (addr)
                    A_BASE_LO: base[31:0]  <= wdata;
                    A_BASE_HI: base[63:32] <= wdata;
                    A_RSIZE:   ring_size   <= wdata[CNT_W-1:0];
                    A_DESC: begin
                        dsize_q  <= wdata[15:0];
                        stride_q <= CNT_W'(wdata[29:16]);
                        tok_q    <= wdata[30];
                    end
                    A_CFG:     cfg_word    <= wdata;
                    A_PTHR:    proc_thr    <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_BASE_LO: rdata = base[31:0];
            A_BASE_HI: rdata = base[63:32];
            A_RSIZE:   rdata = 32'(ring_size);
            A_DESC:    rdata = {1'b0, tok_q, stride_q[13:0], dsize_q};
            A_CFG:     rdata = cfg_word;
            A_PREP:    rdata = 32'(pending);
            A_PROC:    rdata = 32'(proc_cnt);
            A_STAT:    rdata = {31'd0, irq_flag};
            A_PTHR:    rdata = 32'(proc_thr);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/drf_fetch_fsm.sv
module drf_fetch_fsm
    import drf_pkg::*;
#(
    parameter int FIFO_WORDS = 64,
    parameter int CNT_W      = 16,
    parameter int LVL_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [63:0]      base,
    input  logic [CNT_W-1:0] ring_size,
    input  logic [CNT_W-1:0] fsize,
    input  logic [CNT_W-1:0] fthr,
    input  logic [CNT_W-1:0] pending,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             rd_gnt,
    output logic             rd_req,
    output logic [63:0]      rd_addr,
    output logic [CNT_W-1:0] rd_len,
    output logic             sub_vld,
    output logic [CNT_W-1:0] sub_len,
    output logic [CNT_W-1:0] ptr,
    output logic             in_adv
);
    fetch_state_t state_q, state_n;
    logic [CNT_W-1:0] free_w, room_w, len_a, len_c;
    logic [CNT_W:0]   ptr_sum;
    logic             launch;

    always_comb begin
        free_w  = CNT_W'(FIFO_WORDS) - CNT_W'(fifo_level);
        room_w  = ring_size - ptr;
        len_a   = (fsize < pending) ? fsize : pending;
        len_c   = (len_a < room_w) ? len_a : room_w;
        launch  = (fsize != '0) && (pending != '0) && (ring_size != '0)
                  && (ptr < ring_size) && (free_w >= fthr);
        ptr_sum = {1'b0, ptr} + {1'b0, rd_len};
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_n = ST_REQ;
            ST_REQ:  if (rd_gnt) state_n = ST_ADV;
            ST_ADV:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
        if (clr) state_n = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            rd_len  <= '0;
            rd_addr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else begin
            if (state_q == ST_IDLE && launch) begin
                rd_len  <= len_c;
                rd_addr <= base + {{(62-CNT_W){1'b0}}, ptr, 2'b00};
            end
            if (state_q == ST_ADV) begin
                if (ptr_sum >= {1'b0, ring_size}) ptr <= '0;
                else                              ptr <= ptr_sum[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_req  = (state_q == ST_REQ);
        in_adv  = (state_q == ST_ADV);
        sub_vld = in_adv;
        sub_len = rd_len;
    end
endmodule

// File: rtl/drf_irq.sv
module drf_irq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] proc_cnt,
    input  logic [CNT_W-1:0] proc_thr,
    input  logic             st_w1c,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  irq <= 1'b0;
        else if (proc_cnt > proc_thr) irq <= 1'b1;
        else if (st_w1c)             irq <= 1'b0;
    end
endmodule

// File: rtl/drf_ring_fetch.sv
module drf_ring_fetch #(
    parameter int FIFO_WORDS = 64,
    parameter int CNT_W      = 16,
    parameter int LVL_W      = $clog2(FIFO_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             desc_consumed,
    output logic             rd_req,
    input  logic             rd_gnt,
    output logic [63:0]      rd_addr,
    output logic [CNT_W-1:0] rd_len,
    output logic             irq
);
    logic [63:0]      base;
    logic [CNT_W-1:0] ring_size, pending, proc_cnt, proc_thr, sub_len, ptr;
    logic [31:0]      cfg_word;
    logic             clr_ptr, st_w1c, sub_vld, in_adv;

    drf_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .consumed(desc_consumed),
        .sub_vld(sub_vld), .sub_len(sub_len), .irq_flag(irq),
        .base(base), .ring_size(ring_size), .cfg_word(cfg_word),
        .pending(pending), .proc_cnt(proc_cnt), .proc_thr(proc_thr),
        .clr_ptr(clr_ptr), .st_w1c(st_w1c)
    );

    drf_fetch_fsm #(.FIFO_WORDS(FIFO_WORDS), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr_ptr), .base(base),
        .ring_size(ring_size), .fsize(cfg_word[CNT_W-1:0]),
        .fthr(cfg_word[16 +: CNT_W]), .pending(pending),
        .fifo_level(fifo_level), .rd_gnt(rd_gnt), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_len(rd_len), .sub_vld(sub_vld),
        .sub_len(sub_len), .ptr(ptr), .in_adv(in_adv)
    );

    drf_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .proc_cnt(proc_cnt), .proc_thr(proc_thr),
        .st_w1c(st_w1c), .irq(irq)
    );
endmodule

// File: rtl/drf_ring_fetch_chk.sv
module drf_ring_fetch_chk #(
    parameter int FIFO_WORDS = 64,
    parameter int CNT_W      = 16,
    parameter int LVL_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_gnt,
    input logic [63:0]      rd_addr,
    input logic [CNT_W-1:0] rd_len,
    input logic [LVL_W-1:0] fifo_level,
    input logic             clr,
    input logic [31:0]      cfg_word,
    input logic [CNT_W-1:0] ptr,
    input logic [CNT_W-1:0] ring_size,
    input logic             in_adv
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt && !clr) |=> (rd_req && $stable(rd_addr) && $stable(rd_len)));

    assert_enabled_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> ($past(cfg_word[15:0]) != 16'd0));

    assert_free_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> ($past(32'(FIFO_WORDS) - 32'(fifo_level)) >= $past(32'(cfg_word[31:16]))));

    assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> (rd_len != '0 && 32'(rd_len) <= $past(32'(cfg_word[15:0]))));

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_adv && ({1'b0, ptr} + {1'b0, rd_len} == {1'b0, ring_size})) |=> (ptr == '0));
endmodule

bind drf_ring_fetch drf_ring_fetch_chk #(
    .FIFO_WORDS(FIFO_WORDS), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_gnt(rd_gnt),
    .rd_addr(rd_addr), .rd_len(rd_len), .fifo_level(fifo_level),
    .clr(clr_ptr), .cfg_word(cfg_word), .ptr(ptr),
    .ring_size(ring_size), .in_adv(in_adv)
);

// File: tb/drf_ring_fetch_tb.sv
module drf_ring_fetch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FW    = 64;
    localparam int CW    = 16;
    localparam int LW    = 7;
    localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;
    localparam logic [31:0] CFG  = {16'd16, 16'd16};
    localparam int NV = 7;
    localparam int V_ADD[NV] = '{8, 32, 0, 0, 16, 0, 0};
    localparam int V_LVL[NV] = '{0, 60, 48, 0, 10, 0, 0};
    localparam int V_REQ[NV] = '{1, 0, 1, 1, 1, 1, 0};
    localparam int V_OFF[NV] = '{0, 0, 32, 0, 64, 0, 0};
    localparam int V_LEN[NV] = '{8, 0, 16, 16, 8, 8, 0};

    logic clk = 0, rst_n = 0, reg_wr = 0, desc_consumed = 0, rd_gnt = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [LW-1:0] fifo_level = LW'(FW);
    logic rd_req, irq;
    logic [63:0] rd_addr;
    logic [CW-1:0] rd_len;
    int errors = 0, checks = 0, pend = 0;
    logic [31:0] rv;
    bit seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    drf_ring_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_level(fifo_level),
        .desc_consumed(desc_consumed), .rd_req(rd_req), .rd_gnt(rd_gnt),
        .rd_addr(rd_addr), .rd_len(rd_len), .irq(irq)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_req(int n, output bit got);
        got = 0;
        for (int i = 0; i < n && !got; i++) begin
            @(negedge clk);
            if (rd_req) got = 1;
        end
    endtask

    task automatic grant(logic [63:0] ea, int el);
        check("R6 addr", rd_addr, ea);
        check("R5 len", 64'(rd_len), 64'(el));
        @(negedge clk); @(negedge clk);
        check("R7 held", {63'd0, rd_req}, 64'd1);
        check("R7 addr stable", rd_addr, ea);
        rd_gnt = 1; fifo_level = LW'(FW);
        @(negedge clk); rd_gnt = 0;
        @(negedge clk); @(negedge clk);
        pend -= el;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 rd_req", {63'd0, rd_req}, 0);
        check("R1 irq", {63'd0, irq}, 0);
        rd(4'd2, rv); check("R1 ring size", rv, 0);
        rd(4'd5, rv); check("R1 prep", rv, 0);
        rd(4'd6, rv); check("R1 proc", rv, 0);
        rd(4'd7, rv); check("R1 status", rv, 0);

        wr(4'd0, BASE[31:0]); wr(4'd1, BASE[63:32]); wr(4'd2, 32'd24);
        wr(4'd3, 32'h4008_0006); wr(4'd4, CFG); wr(4'd8, 32'd20);
        rd(4'd0, rv); check("R2 base lo", rv, BASE[31:0]);
        rd(4'd1, rv); check("R2 base hi", rv, BASE[63:32]);
        rd(4'd2, rv); check("R2 ring size", rv, 24);
        rd(4'd3, rv); check("R2 desc word", rv, 32'h4008_0006);
        rd(4'd4, rv); check("R2 cfg", rv, CFG);

        // table walk: R4 R5 R6 R8
        for (int k = 0; k < NV; k++) begin
            if (V_ADD[k] != 0) begin
                wr(4'd5, 32'(V_ADD[k])); pend += V_ADD[k];
            end
            fifo_level = LW'(V_LVL[k]);
            wait_req(8, seen);
            check("R4 request presence", {63'd0, seen}, 64'(V_REQ[k]));
            if (seen) grant(BASE + 64'(V_OFF[k]), V_LEN[k]);
            else fifo_level = LW'(FW);
            rd(4'd5, rv); check("R8 pending", rv, 32'(pend));
        end

        // R3: disabled fetch
        wr(4'd4, 32'h0010_0000); wr(4'd5, 32'd8); pend += 8;
        fifo_level = 0;
        wait_req(8, seen); check("R3 no request when disabled", {63'd0, seen}, 0);
        wr(4'd4, CFG);
        wait_req(8, seen); check("R3 request after enable", {63'd0, seen}, 1);
        if (seen) grant(BASE + 64'd32, 8);

        // R9: count reset clears pending and pointer
        wr(4'd5, 32'd8);
        rd(4'd5, rv); check("R9 before reset", rv, 8);
        wr(4'd5, 32'h8000_0000);
        rd(4'd5, rv); check("R9 cleared", rv, 0);
        pend = 8; wr(4'd5, 32'd8); fifo_level = 0;
        wait_req(8, seen); check("R9 request", {63'd0, seen}, 1);
        if (seen) grant(BASE, 8);

        // R10 and R11
        for (int j = 0; j < 3; j++) begin
            @(negedge clk); desc_consumed = 1;
            @(negedge clk); desc_consumed = 0;
        end
        @(negedge clk);
        rd(4'd6, rv); check("R10 processed", rv, 24);
        check("R11 irq set", {63'd0, irq}, 1);
        rd(4'd7, rv); check("R11 status bit", rv, 1);
        wr(4'd7, 32'd1); @(negedge clk);
        check("R11 sticky while above", {63'd0, irq}, 1);
        wr(4'd6, 32'd8);
        rd(4'd6, rv); check("R10 subtract", rv, 16);
        wr(4'd7, 32'd1); @(negedge clk);
        check("R11 cleared", {63'd0, irq}, 0);
        wr(4'd6, 32'h8000_0000);
        rd(4'd6, rv); check("R10 reset code", rv, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule